// File: doc/BRIEF.md
# Dual-Range Current-Sense Mode Controller

This block is the digital control for the current-sense path of a multi-channel load switch. For each channel it tracks whether sensing runs at the coarse, high-current ratio or at the fine, low-current ratio. Software asks for the fine ratio through a request bit. Two comparator flags from the analog side report whether the load current is under the entry threshold or over the exit threshold. These flags decide whether the request takes effect and whether the fine ratio must be dropped.

The block also gates sensing on each channel. A channel is sensed only when it is switched on, it is past its inrush period, and neither the global disable nor its own disable is set. When an ADC scheduler strobes a finished conversion for a sensed channel, the block latches the 10-bit code into that channel's result register. It stores with it the gain that applied to the sample and a ready flag. Reading the result register clears the ready flag.

Top module: `cs_range_ctrl`

## Requirements
- R1: Writing 1 to bit 0 (fine-ratio request) of a channel's config register (address 1+2c) selects the fine ratio only when that channel's below-entry flag is high in the write cycle. Otherwise the channel stays coarse and bit 0 reads back 0.
- R2: While the fine ratio is active, a high above-exit flag returns the channel to the coarse ratio on the next edge, and bit 0 of its config register reads 0.
- R3: After any exit from the fine ratio, the channel stays coarse until software writes bit 0 to 1 again, even if the below-entry flag returns high.
- R4: Writing 0 to bit 0 of the config register leaves the fine ratio on the next edge, whatever the comparator flags say.
- R5: A conversion strobe for a sensed channel stores the 10-bit code in bits [9:0] of that channel's result register (address 2+2c). Other channels' results are not touched.
- R6: Bit 11 of the result register (ready) is set by every capture. A read strobe on that address clears it on the next edge, unless a capture for the channel happens in the same cycle, in which case it stays set. The read itself returns the value held before the edge.
- R7: Bit 1 of the config register selects gain x8 (1) or x1 (0). The gain is effectively x8 only when bit 1 is 1 and the fine ratio is active. The output gain_x8 shows this. Bit 10 of each stored result holds the effective gain at capture time.
- R8: A channel is sensed (sense_en high) only when bit 0 of address 0 (global disable) is 0, bit 2 of its config register (channel disable) is 0, its on flag is high and its steady flag is high. All disables are 0 after reset, and all registers reset to 0.
- R9: A conversion strobe for a channel that is not sensed changes neither the stored code, the gain bit nor the ready bit of that channel.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (clears ready on result reads) |
| reg_addr | input | AW | Register address |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data, combinational from reg_addr |
| ch_on | input | NCH | Channel switched on |
| ch_steady | input | NCH | Channel past its inrush period |
| below_entry | input | NCH | Load current under the fine-ratio entry threshold |
| above_exit | input | NCH | Load current over the fine-ratio exit threshold |
| conv_done | input | 1 | Conversion finished strobe |
| conv_ch | input | CW | Channel the finished conversion belongs to |
| conv_data | input | RES_W | Conversion code |
| sense_en | output | NCH | Channel is being sensed |
| low_range | output | NCH | Fine ratio active |
| gain_x8 | output | NCH | Effective sense gain is x8 |

## Verification
Every state change (mode, gain, disables, stored result, ready) is registered once. It shows on reg_rdata, low_range and gain_x8 one edge after its strobe. sense_en is combinational and follows the on and steady inputs in the same cycle. reg_rdata is combinational from reg_addr, so a read strobe sees the pre-edge value and the cleared ready only after the edge. The bench drives every stimulus on a falling edge and samples at the next falling edge, one full register stage later. For same-cycle read values it samples just after driving, before the rising edge.

// File: rtl/cs_range_ctrl.sv
module cs_range_ctrl #(
  parameter int NCH   = 2,
  parameter int RES_W = 10,
  parameter int AW    = 4,
  parameter int CW    = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reg_wr,
  input  logic             reg_rd,
  input  logic [AW-1:0]    reg_addr,
  input  logic [15:0]      reg_wdata,
  output logic [15:0]      reg_rdata,
  input  logic [NCH-1:0]   ch_on,
  input  logic [NCH-1:0]   ch_steady,
  input  logic [NCH-1:0]   below_entry,
  input  logic [NCH-1:0]   above_exit,
  input  logic             conv_done,
  input  logic [CW-1:0]    conv_ch,
  input  logic [RES_W-1:0] conv_data,
  output logic [NCH-1:0]   sense_en,
  output logic [NCH-1:0]   low_range,
  output logic [NCH-1:0]   gain_x8
);

  localparam int PADC = 16 - 3;
  localparam int PADR = 16 - RES_W - 2;

  logic             gdis_q;
  logic [NCH-1:0]   low_q, scale_q, cdis_q, seff_q, rdy_q;
  logic [RES_W-1:0] res_q [NCH];
  logic [NCH-1:0]   wr_cfg, rd_res, cap;

  wire unused_wdata = ^reg_wdata[15:3];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)                      gdis_q <= 1'b0;
    else if (reg_wr && reg_addr == '0) gdis_q <= reg_wdata[0];

  assign low_range = low_q;
  assign gain_x8   = low_q & scale_q;

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    assign wr_cfg[c]   = reg_wr && reg_addr == AW'(2*c + 1);
    assign rd_res[c]   = reg_rd && reg_addr == AW'(2*c + 2);
    assign sense_en[c] = !gdis_q && !cdis_q[c] && ch_on[c] && ch_steady[c];
    assign cap[c]      = conv_done && conv_ch == CW'(c) && sense_en[c];

    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) begin
        low_q[c]   <= 1'b0;
        scale_q[c] <= 1'b0;
        cdis_q[c]  <= 1'b0;
      end else begin
        if (wr_cfg[c]) begin
          low_q[c]   <= reg_wdata[0] && below_entry[c] && !above_exit[c];
          scale_q[c] <= reg_wdata[1];
          cdis_q[c]  <= reg_wdata[2];
        end else if (above_exit[c]) begin
          low_q[c]   <= 1'b0;
        end
      end

    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) begin
        res_q[c]  <= '0;
        seff_q[c] <= 1'b0;
        rdy_q[c]  <= 1'b0;
      end else if (cap[c]) begin
        res_q[c]  <= conv_data;
        seff_q[c] <= gain_x8[c];
        rdy_q[c]  <= 1'b1;
      end else if (rd_res[c]) begin
        rdy_q[c]  <= 1'b0;
      end

    // R1
    entry_cond_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(low_q[c]) |-> $past(below_entry[c]) && $past(wr_cfg[c]));
    // R2
    auto_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (low_q[c] && above_exit[c]) |=> !low_q[c]);
    // R3
    no_reentry_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!low_q[c] && !wr_cfg[c]) |=> !low_q[c]);
    // R6
    ready_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cap[c] |=> rdy_q[c]);
    // R9
    ignored_conv_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (conv_done && !sense_en[c]) |=> $stable(res_q[c]) && $stable(seff_q[c]));
  end

  always_comb begin
    reg_rdata = '0;
    if (reg_addr == '0) reg_rdata = {15'b0, gdis_q};
    for (int c = 0; c < NCH; c++) begin
      if (reg_addr == AW'(2*c + 1))
        reg_rdata = {{PADC{1'b0}}, cdis_q[c], scale_q[c], low_q[c]};
      if (reg_addr == AW'(2*c + 2))
        reg_rdata = {{PADR{1'b0}}, rdy_q[c], seff_q[c], res_q[c]};
    end
  end

endmodule

// File: tb/cs_range_ctrl_bench.sv
module cs_range_ctrl_bench;
  localparam int CLK_P = 10;

  logic        clk = 0, rst_n = 0;
  logic        reg_wr = 0, reg_rd = 0;
  logic [3:0]  reg_addr = 0;
  logic [15:0] reg_wdata = 0, reg_rdata;
  logic [1:0]  ch_on = 2'b11, ch_steady = 2'b11, below_entry = 0, above_exit = 0;
  logic        conv_done = 0;
  logic [0:0]  conv_ch = 0;
  logic [9:0]  conv_data = 0;
  logic [1:0]  sense_en, low_range, gain_x8;
  int checks = 0, errors = 0;

  always #(CLK_P/2) clk = ~clk;

  cs_range_ctrl u_cs_range_ctrl (
    .clk, .rst_n, .reg_wr, .reg_rd, .reg_addr, .reg_wdata, .reg_rdata,
    .ch_on, .ch_steady, .below_entry, .above_exit,
    .conv_done, .conv_ch, .conv_data, .sense_en, .low_range, .gain_x8);

  // [15]wr [14:12]addr [11:8]wdata [7]below [6]above [5]on [4]steady [3]pad
  // [2]exp low_range [1]exp gain_x8 [0]exp sense_en
  localparam logic [15:0] VEC [13] = '{
    {1'b1,3'd1,4'h1,1'b0,1'b0,1'b1,1'b1,1'b0,3'b001},
    {1'b1,3'd1,4'h3,1'b1,1'b0,1'b1,1'b1,1'b0,3'b111},
    {1'b0,3'd1,4'h0,1'b1,1'b0,1'b1,1'b1,1'b0,3'b111},
    {1'b0,3'd1,4'h0,1'b0,1'b1,1'b1,1'b1,1'b0,3'b001},
    {1'b0,3'd1,4'h0,1'b1,1'b0,1'b1,1'b1,1'b0,3'b001},
    {1'b1,3'd1,4'h1,1'b1,1'b0,1'b1,1'b1,1'b0,3'b101},
    {1'b1,3'd1,4'h0,1'b1,1'b0,1'b1,1'b1,1'b0,3'b001},
    {1'b1,3'd1,4'h1,1'b1,1'b0,1'b1,1'b1,1'b0,3'b101},
    {1'b1,3'd1,4'h5,1'b1,1'b0,1'b1,1'b1,1'b0,3'b100},
    {1'b1,3'd1,4'h1,1'b1,1'b0,1'b1,1'b0,1'b0,3'b100},
    {1'b0,3'd1,4'h0,1'b1,1'b0,1'b0,1'b1,1'b0,3'b100},
    {1'b1,3'd0,4'h1,1'b1,1'b0,1'b1,1'b1,1'b0,3'b100},
    {1'b1,3'd0,4'h0,1'b1,1'b0,1'b1,1'b1,1'b0,3'b101}
  };

  task automatic check(string tag, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr_reg(logic [3:0] a, logic [15:0] d);
    @(negedge clk); reg_wr = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_wr = 0;
  endtask

  task automatic conv(logic c, logic [9:0] d);
    @(negedge clk); conv_done = 1; conv_ch = c; conv_data = d;
    @(negedge clk); conv_done = 0;
  endtask

  task automatic peek(logic [3:0] a, output logic [15:0] v);
    reg_addr = a; #1; v = reg_rdata;
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual hung expected done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [15:0] v;
    repeat (2) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R8 reset state
    peek(0, v); check("R8 reset global", v, 16'h0);
    peek(1, v); check("R8 reset cfg", v, 16'h0);
    peek(2, v); check("R5 reset result", v, 16'h0);
    check("R8 reset sense", {14'b0, sense_en}, 16'h3);
    check("R1 reset low", {14'b0, low_range}, 16'h0);

    foreach (VEC[i]) begin
      @(negedge clk);
      reg_wr = VEC[i][15]; reg_addr = {1'b0, VEC[i][14:12]};
      reg_wdata = {12'b0, VEC[i][11:8]};
      below_entry[0] = VEC[i][7]; above_exit[0] = VEC[i][6];
      ch_on[0] = VEC[i][5]; ch_steady[0] = VEC[i][4];
      @(negedge clk); reg_wr = 0;
      check($sformatf("R1/R2/R3/R4/R7/R8 vector %0d", i),
            {13'b0, low_range[0], gain_x8[0], sense_en[0]}, {13'b0, VEC[i][2:0]});
    end

    // R2 request bit reads back 0 after auto exit
    wr_reg(1, 16'h3);
    above_exit[0] = 1; below_entry[0] = 0;
    @(negedge clk); above_exit[0] = 0;
    peek(1, v); check("R2 request cleared", v, 16'h2);
    // R1 request bit reads 0 when entry refused
    wr_reg(1, 16'h1);
    peek(1, v); check("R1 refused entry readback", v, 16'h0);

    below_entry[0] = 1;
    wr_reg(1, 16'h3);
    conv(0, 10'h2A5);
    // R5 R7 capture with x8 effective
    @(negedge clk); reg_rd = 1; reg_addr = 2; #1;
    check("R5 R7 result before read", reg_rdata, 16'h0EA5);
    @(negedge clk); reg_rd = 0;
    peek(2, v); check("R6 ready cleared by read", v, 16'h06A5);
    @(negedge clk);
    peek(2, v); check("R6 stays clear without capture", v, 16'h06A5);

    above_exit[0] = 1; @(negedge clk); above_exit[0] = 0;
    check("R7 gain x1 after exit", {15'b0, gain_x8[0]}, 16'h0);
    conv(0, 10'h0FF);
    peek(2, v); check("R7 result scale x1", v, 16'h08FF);

    // R6 read and capture in same cycle
    @(negedge clk); reg_rd = 1; reg_addr = 2; conv_done = 1; conv_ch = 0; conv_data = 10'h123;
    @(negedge clk); reg_rd = 0; conv_done = 0;
    peek(2, v); check("R6 capture beats read", v, 16'h0923);

    // R9 ignored strobes
    wr_reg(1, 16'h4);
    conv(0, 10'h3FF);
    peek(2, v); check("R9 channel disabled", v, 16'h0923);
    wr_reg(1, 16'h0);
    wr_reg(0, 16'h1);
    conv(0, 10'h3FF);
    peek(2, v); check("R9 global disabled", v, 16'h0923);
    wr_reg(0, 16'h0);
    ch_steady[0] = 0;
    conv(0, 10'h3FF);
    peek(2, v); check("R9 inrush", v, 16'h0923);
    ch_steady[0] = 1; ch_on[0] = 0;
    conv(0, 10'h3FF);
    peek(2, v); check("R9 channel off", v, 16'h0923);
    ch_on[0] = 1;

    // R5 per-channel storage
    conv(1, 10'h055);
    peek(4, v); check("R5 channel 1 result", v, 16'h0855);
    peek(2, v); check("R5 channel 0 untouched", v, 16'h0923);

    @(negedge clk);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule